// File: doc/BRIEF.md
# Virtual-Index Physical-Tag L1 Lookup

This block is the lookup path of a small L1 data cache. It chooses the set from address bits that fall inside the page offset, so these bits are the same before and after translation. That lets the tag and data arrays be read in the same cycle in which an external TLB starts translating the page number. In the following cycle the physical page number (PPN) from the TLB is compared against the stored tag of every way at once. The result is hit, miss or translation fault, together with the addressed word on a hit. The cache has 2^WAY_LOG ways. Each way is a direct-mapped bank of 2^IDX_W lines, and each line holds 2^OFF_W words of DATA_W bits. Addresses are in word units.

A miss starts a refill. The block requests the line by physical line address from the next level, waits for the line to arrive, and writes it into the way that a round-robin pointer selects. The block does not replay the request; the pipeline issues it again. A configuration with IDX_W + OFF_W greater than PAGE_OFF_W could store one physical line under two set numbers, so elaboration stops with an error for it.

The controller has three states:
- S_IDLE: ready for a request.
- S_LOOKUP: the compare cycle.
- S_REFILL: waiting for the line.

Its transitions are:
- IDLE→LOOKUP when a request is accepted.
- LOOKUP→IDLE on a hit or a fault.
- LOOKUP→REFILL on a miss.
- REFILL→IDLE when the refill line arrives.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset every line is invalid. req_ready is 1, and rsp_valid and refill_req_valid are 0. The first lookup of any address reports a miss.
- R2: A request accepted at a clock edge (req_valid and req_ready both 1) gives rsp_valid = 1 during exactly the next cycle. req_ready is 0 in every cycle that is not S_IDLE.
- R3: The set number is req_voff[OFF_W+IDX_W-1:OFF_W]. The word number is req_voff[OFF_W-1:0]. Word w of a line occupies bits [w*DATA_W +: DATA_W]. On a hit, rsp_data is that word; otherwise rsp_data is 0.
- R4: The hit decision uses the tlb_ppn/tlb_valid/tlb_fault values present in the response cycle. TLB values present during the acceptance cycle have no effect. rsp_hit is 1 only when some valid way of the set holds a tag equal to tlb_ppn.
- R5: If tlb_valid is 0 or tlb_fault is 1 in the response cycle, the response has rsp_fault = 1 and rsp_hit = 0. No refill is issued, and req_ready is 1 again in the next cycle.
- R6: After a miss response (rsp_valid 1, hit 0, fault 0), refill_req_valid is 1 from the next cycle. refill_req_addr = {PPN, set}, and both are held until the cycle in which refill_rsp_valid is 1.
- R7: The refill line is written into the way named by one cache-wide round-robin pointer. The pointer starts at way 0 and advances by one on each refill. A later lookup of the same address hits and returns the refilled data.
- R8: With two ways, two different PPNs can be held in the same set at once. A third PPN in that set replaces the line in the way the pointer names.
- R9: refill_rsp_valid is ignored in any cycle outside S_REFILL. It changes no line, and no response or refill request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU lookup request |
| req_ready | output | 1 | Block can accept a request |
| req_voff | input | PAGE_OFF_W | Page-offset bits of the virtual word address |
| tlb_valid | input | 1 | TLB result present (response cycle) |
| tlb_ppn | input | PPN_W | Translated physical page number |
| tlb_fault | input | 1 | Page fault or protection violation |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fault | output | 1 | Translation missing or faulting |
| rsp_data | output | DATA_W | Addressed word on a hit, else 0 |
| refill_req_valid | output | 1 | Line request to next level |
| refill_req_addr | output | PPN_W+IDX_W | Physical line address {PPN, set} |
| refill_rsp_valid | input | 1 | Refill line delivered |
| refill_rsp_line | input | DATA_W<<OFF_W | Refill line data |

## Verification
A wrong valid bit or tag in a way shows at the ports in the response cycle of the next lookup to that set. It appears as a hit that should be a miss, which also suppresses the refill request, or the reverse. A wrong round-robin pointer stays invisible until the third distinct page in one set. It then evicts the wrong line, and the next lookup of the page that should have survived comes back as a miss. A state error shows within one cycle: req_ready is up while a response or refill is pending, or a refill request is missing after a miss.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_REFILL = 2'd2
    } lookup_state_e;
endpackage

// File: rtl/vipt_way_bank.sv
// One direct-mapped way: valid bits with reset, tag and line storage.
// The read is registered at the edge that accepts the request.
module vipt_way_bank #(
    parameter int IDX_W  = 6,
    parameter int PPN_W  = 20,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PPN_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic              rd_valid,
    output logic [PPN_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [PPN_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_en) valid_q[wr_idx] <= 1'b1;
            if (rd_en) rd_valid <= valid_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
        if (rd_en) begin
            rd_tag  <= tag_mem[rd_idx];
            rd_line <= line_mem[rd_idx];
        end
    end
endmodule

// File: rtl/vipt_tag_match.sv
// Parallel physical-tag compare across all ways and word selection.
module vipt_tag_match #(
    parameter int WAYS   = 2,
    parameter int PPN_W  = 20,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32,
    localparam int LINE_W = DATA_W << OFF_W
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][PPN_W-1:0]  way_tag,
    input  logic [WAYS-1:0][LINE_W-1:0] way_line,
    input  logic [PPN_W-1:0]            ppn,
    input  logic [OFF_W-1:0]            word_sel,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        any_hit,
    output logic [DATA_W-1:0]           word
);
    for (genvar i = 0; i < WAYS; i++) begin : g_cmp
        assign hit_vec[i] = way_valid[i] && (way_tag[i] == ppn);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        word = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) word |= way_line[i][int'(word_sel)*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/vipt_rr_victim.sv
// Cache-wide round-robin victim pointer.
module vipt_rr_victim #(
    parameter int WAY_LOG = 1,
    localparam int PTR_W  = (WAY_LOG > 0) ? WAY_LOG : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [PTR_W-1:0] way_ptr
);
    if (WAY_LOG == 0) begin : g_single
        assign way_ptr = '0;
    end else begin : g_rr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       way_ptr <= '0;
            else if (advance) way_ptr <= way_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
    import vipt_pkg::*;
#(
    parameter int PAGE_OFF_W = 8,
    parameter int IDX_W      = 6,
    parameter int OFF_W      = 2,
    parameter int WAY_LOG    = 1,
    parameter int PPN_W      = 20,
    parameter int DATA_W     = 32,
    localparam int LINE_W    = DATA_W << OFF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [PAGE_OFF_W-1:0]  req_voff,
    input  logic                   tlb_valid,
    input  logic [PPN_W-1:0]       tlb_ppn,
    input  logic                   tlb_fault,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_fault,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   refill_req_valid,
    output logic [PPN_W+IDX_W-1:0] refill_req_addr,
    input  logic                   refill_rsp_valid,
    input  logic [LINE_W-1:0]      refill_rsp_line
);
    localparam int WAYS  = 1 << WAY_LOG;
    localparam int PTR_W = (WAY_LOG > 0) ? WAY_LOG : 1;

    // Alias freedom: the set index and word offset must lie inside the page offset.
    if (IDX_W + OFF_W > PAGE_OFF_W) begin : g_alias_reject
        $error("set index plus line offset exceed the page offset width");
    end
    if (OFF_W < 1) begin : g_off_reject
        $error("a line must hold at least two words");
    end

    lookup_state_e state_q, state_d;

    logic                        accept;
    logic [IDX_W-1:0]            rd_idx;
    logic [IDX_W-1:0]            idx_q;
    logic [OFF_W-1:0]            word_q;
    logic [PPN_W-1:0]            ppn_q;
    logic [WAYS-1:0]             way_valid;
    logic [WAYS-1:0][PPN_W-1:0]  way_tag;
    logic [WAYS-1:0][LINE_W-1:0] way_line;
    logic [WAYS-1:0]             hit_vec;
    logic                        any_hit;
    logic [DATA_W-1:0]           sel_word;
    logic [PTR_W-1:0]            victim;
    logic                        fill_now;
    logic                        xlat_bad;
    logic                        look_hit;

    assign accept   = req_valid && (state_q == S_IDLE);
    assign rd_idx   = req_voff[OFF_W +: IDX_W];
    assign fill_now = (state_q == S_REFILL) && refill_rsp_valid;
    assign xlat_bad = !tlb_valid || tlb_fault;
    assign look_hit = any_hit && !xlat_bad;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        vipt_way_bank #(
            .IDX_W (IDX_W),
            .PPN_W (PPN_W),
            .LINE_W(LINE_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (accept),
            .rd_idx  (rd_idx),
            .wr_en   (fill_now && (int'(victim) == w)),
            .wr_idx  (idx_q),
            .wr_tag  (ppn_q),
            .wr_line (refill_rsp_line),
            .rd_valid(way_valid[w]),
            .rd_tag  (way_tag[w]),
            .rd_line (way_line[w])
        );
    end

    vipt_tag_match #(
        .WAYS  (WAYS),
        .PPN_W (PPN_W),
        .OFF_W (OFF_W),
        .DATA_W(DATA_W)
    ) u_match (
        .way_valid(way_valid),
        .way_tag  (way_tag),
        .way_line (way_line),
        .ppn      (tlb_ppn),
        .word_sel (word_q),
        .hit_vec  (hit_vec),
        .any_hit  (any_hit),
        .word     (sel_word)
    );

    vipt_rr_victim #(
        .WAY_LOG(WAY_LOG)
    ) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(fill_now),
        .way_ptr(victim)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_LOOKUP;
            S_LOOKUP: state_d = (look_hit || xlat_bad) ? S_IDLE : S_REFILL;
            S_REFILL: if (refill_rsp_valid) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register and request context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
            ppn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                idx_q  <= rd_idx;
                word_q <= req_voff[OFF_W-1:0];
            end
            if (state_q == S_LOOKUP) ppn_q <= tlb_ppn;
        end
    end

    // Outputs.
    always_comb begin
        req_ready        = 1'b0;
        rsp_valid        = 1'b0;
        rsp_hit          = 1'b0;
        rsp_fault        = 1'b0;
        rsp_data         = '0;
        refill_req_valid = 1'b0;
        refill_req_addr  = {ppn_q, idx_q};
        unique case (state_q)
            S_IDLE:   req_ready = 1'b1;
            S_LOOKUP: begin
                rsp_valid = 1'b1;
                rsp_hit   = look_hit;
                rsp_fault = xlat_bad;
                if (look_hit) rsp_data = sel_word;
            end
            S_REFILL: refill_req_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input logic          rsp_fault,
    input logic          refill_req_valid,
    input logic [AW-1:0] refill_req_addr,
    input logic          refill_rsp_valid
);
    // R1
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R2
    accept_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R2
    rsp_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || refill_req_valid) |-> !req_ready);

    // R5
    fault_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_hit);

    // R5
    fault_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |=> !refill_req_valid);

    // R6
    refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req_valid && !refill_rsp_valid) |=>
            (refill_req_valid && $stable(refill_req_addr)));

    // R6
    refill_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refill_req_valid) |-> $past(rsp_valid && !rsp_hit && !rsp_fault));
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(
    .AW(PPN_W + IDX_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_fault       (rsp_fault),
    .refill_req_valid(refill_req_valid),
    .refill_req_addr (refill_req_addr),
    .refill_rsp_valid(refill_rsp_valid)
);

// File: tb/vipt_l1_lookup_tb.sv
module vipt_l1_lookup_tb;
    localparam int PAGE_OFF_W = 8;
    localparam int IDX_W      = 6;
    localparam int OFF_W      = 2;
    localparam int WAY_LOG    = 1;
    localparam int PPN_W      = 20;
    localparam int DATA_W     = 32;
    localparam int WAYS       = 1 << WAY_LOG;
    localparam int SETS       = 1 << IDX_W;
    localparam int WORDS      = 1 << OFF_W;
    localparam int LINE_W     = DATA_W * WORDS;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic [PAGE_OFF_W-1:0]  req_voff = '0;
    logic                   tlb_valid = 1'b0;
    logic [PPN_W-1:0]       tlb_ppn = '0;
    logic                   tlb_fault = 1'b0;
    logic                   rsp_valid;
    logic                   rsp_hit;
    logic                   rsp_fault;
    logic [DATA_W-1:0]      rsp_data;
    logic                   refill_req_valid;
    logic [PPN_W+IDX_W-1:0] refill_req_addr;
    logic                   refill_rsp_valid = 1'b0;
    logic [LINE_W-1:0]      refill_rsp_line = '0;

    always #5 clk = ~clk;

    vipt_l1_lookup #(
        .PAGE_OFF_W(PAGE_OFF_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .WAY_LOG(WAY_LOG), .PPN_W(PPN_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_voff(req_voff),
        .tlb_valid(tlb_valid), .tlb_ppn(tlb_ppn), .tlb_fault(tlb_fault),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_data(rsp_data),
        .refill_req_valid(refill_req_valid), .refill_req_addr(refill_req_addr),
        .refill_rsp_valid(refill_rsp_valid), .refill_rsp_line(refill_rsp_line)
    );

    typedef struct packed {
        logic [3:0]        rq;
        logic              hit;
        logic              fault;
        logic [DATA_W-1:0] data;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Reference contents, built from the requirements.
    logic             mv [SETS][WAYS];
    logic [PPN_W-1:0] mt [SETS][WAYS];
    int               rr = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    function automatic logic [DATA_W-1:0] word_of(input logic [PPN_W-1:0] p, input int idx, input int w);
        return {p[15:0], 16'h0} ^ DATA_W'(idx << 6) ^ DATA_W'(w) ^ 32'h3C5A_0900;
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input logic [PPN_W-1:0] p, input int idx);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = word_of(p, idx, w);
        return l;
    endfunction

    // Monitor: pop expected items as responses appear (sampled 1 ns before the edge).
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (rsp_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected response", 64'(rsp_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(rsp_hit == e.hit && rsp_fault == e.fault && rsp_data == e.data,
                        $sformatf("R%0d", e.rq), "hit/fault/data",
                        {rsp_hit, rsp_fault, 30'd0, rsp_data}, {e.hit, e.fault, 30'd0, e.data});
                end
            end
        end
    end

    // Driver: one lookup, including any refill it triggers.
    task automatic access(input int idx, input int w, input logic [PPN_W-1:0] ppn,
                          input bit ok, input bit flt, input int dly, input logic [3:0] rq);
        exp_t e;
        bit   fault;
        int   hw;
        fault = !ok || flt;
        hw = -1;
        for (int i = 0; i < WAYS; i++) if (mv[idx][i] && mt[idx][i] == ppn) hw = i;
        @(negedge clk);
        req_valid = 1'b1;
        req_voff  = {IDX_W'(idx), OFF_W'(w)};
        // R4: decoy translation during the acceptance cycle
        tlb_valid = 1'b1;
        tlb_ppn   = ~ppn;
        tlb_fault = 1'b0;
        e.rq    = rq;
        e.hit   = !fault && hw >= 0;
        e.fault = fault;
        e.data  = e.hit ? word_of(ppn, idx, w) : '0;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        tlb_valid = ok;
        tlb_ppn   = ppn;
        tlb_fault = flt;
        @(negedge clk);
        tlb_valid = 1'b0;
        tlb_fault = 1'b0;
        if (!fault && hw < 0) begin
            #1;
            chk(refill_req_valid == 1'b1, "R6", "refill request raised", 64'(refill_req_valid), 64'd1);
            chk(refill_req_addr == {ppn, IDX_W'(idx)}, "R6", "refill address",
                64'(refill_req_addr), 64'({ppn, IDX_W'(idx)}));
            chk(req_ready == 1'b0, "R2", "ready low during refill", 64'(req_ready), 64'd0);
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                #1;
                chk(refill_req_valid && refill_req_addr == {ppn, IDX_W'(idx)}, "R6",
                    "refill request held", 64'(refill_req_addr), 64'({ppn, IDX_W'(idx)}));
            end
            @(negedge clk);
            refill_rsp_valid = 1'b1;
            refill_rsp_line  = line_of(ppn, idx);
            @(negedge clk);
            refill_rsp_valid = 1'b0;
            refill_rsp_line  = '0;
            mv[idx][rr] = 1'b1;
            mt[idx][rr] = ppn;
            rr = (rr + 1) % WAYS;
            chk(req_ready == 1'b1 && refill_req_valid == 1'b0, "R7", "idle after refill",
                {req_ready, refill_req_valid}, 64'd2);
        end else begin
            chk(refill_req_valid == 1'b0, "R5", "no refill after hit or fault", 64'(refill_req_valid), 64'd0);
            chk(req_ready == 1'b1, "R2", "ready again", 64'(req_ready), 64'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [PPN_W-1:0] pa, pb, pc, pd;
        int lcg;
        pa = 20'h12345; pb = 20'h0ABCD; pc = 20'hF0F0F; pd = 20'h77001;
        for (int s = 0; s < SETS; s++)
            for (int i = 0; i < WAYS; i++) begin mv[s][i] = 1'b0; mt[s][i] = '0; end

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && refill_req_valid == 1'b0, "R1",
            "reset outputs", {req_ready, rsp_valid, refill_req_valid}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && refill_req_valid == 1'b0, "R1",
            "outputs after reset", {req_ready, rsp_valid, refill_req_valid}, 64'd4);

        // R1 cold miss, R6 refill, then R3/R4 hits on every word
        access(5, 2, pa, 1, 0, 2, 4'd1);
        for (int w = 0; w < WORDS; w++) access(5, w, pa, 1, 0, 0, 4'd3);
        // R3: same page, other sets (boundaries 0 and last)
        access(0, 1, pa, 1, 0, 0, 4'd3);
        access(0, 1, pa, 1, 0, 0, 4'd3);
        access(SETS-1, 3, pa, 1, 0, 1, 4'd3);
        access(SETS-1, 3, pa, 1, 0, 0, 4'd3);
        // R4: different PPN, same set is a miss; refill goes to way 1 (R7)
        access(5, 0, pb, 1, 0, 0, 4'd4);
        // R8: both pages coexist
        access(5, 1, pa, 1, 0, 0, 4'd8);
        access(5, 3, pb, 1, 0, 0, 4'd8);
        // R8/R7: third page evicts the line in the pointed way
        access(5, 0, pc, 1, 0, 0, 4'd8);
        access(5, 2, pc, 1, 0, 0, 4'd7);
        access(5, 2, pb, 1, 0, 0, 4'd8);
        access(5, 2, pa, 1, 0, 0, 4'd8);
        // R5: faults on a resident line and on an absent one, and missing translation
        access(5, 2, pa, 1, 1, 0, 4'd5);
        access(7, 0, pd, 1, 1, 0, 4'd5);
        access(7, 0, pd, 0, 0, 0, 4'd5);
        access(7, 0, pd, 0, 1, 0, 4'd5);

        // R9: stray refill line while idle
        @(negedge clk);
        refill_rsp_valid = 1'b1;
        refill_rsp_line  = line_of(pd, 9);
        @(negedge clk);
        refill_rsp_valid = 1'b0;
        refill_rsp_line  = '0;
        #1;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && refill_req_valid == 1'b0, "R9",
            "idle unchanged after stray line", {req_ready, rsp_valid, refill_req_valid}, 64'd4);
        access(9, 0, pd, 1, 0, 0, 4'd9);
        access(9, 1, pd, 1, 0, 0, 4'd9);

        // Mixed sweep
        lcg = 32'h1234;
        for (int n = 0; n < 300; n++) begin
            int idx, w, sel;
            bit ok, flt;
            logic [PPN_W-1:0] p;
            lcg = lcg * 1103515245 + 12345;
            idx = ((lcg >>> 16) & 3) * 21;
            w   = (lcg >>> 8) & 3;
            sel = (lcg >>> 20) % 3;
            p   = (sel == 0) ? pa : (sel == 1) ? pb : pc;
            ok  = ((lcg >>> 24) & 7) != 0;
            flt = ((lcg >>> 27) & 7) == 0;
            access(idx, w, p, ok, flt, (lcg >>> 4) & 3, 4'd4);
        end

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R2", "all responses seen", 64'(sbq.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule